// File: doc/BRIEF.md
# Miss Status Holding Register File

This block tracks outstanding line fills for a non-blocking data cache in an in-order pipeline. A load that misses does not freeze the pipeline. Instead it claims a tracking entry that records the line address and notes, per word of the line, which destination register is waiting for that word. A second miss to a line that is already being fetched joins the existing entry and no new memory request is sent. The block keeps a full/empty bit per architectural register, so decode can hold any instruction whose source operand is still in flight.

When memory returns a line, the entry named by the fill drains its waiting words onto a single register writeback port. It writes one register per cycle in ascending word order and marks each register full once it has been written. After its last word has been written, the entry is freed. Only when every entry is busy does a miss to a new line stall.

Top module: `miss_tracker`

## Requirements
- R1: After reset no entry is in use, every register reads as full, and `wb_valid` and `mem_req_valid` are low.
- R2: A miss to a line not held by a waiting entry, with a free entry available, is accepted in the same cycle (`miss_stall` low). In the next cycle `mem_req_valid` pulses for one cycle, carrying the line and the lowest free entry index.
- R3: A miss to a line held by an entry that is still waiting for its fill is merged into that entry: no stall and no memory request.
- R4: From the cycle after a miss is accepted, its destination register reads as empty. `dec_hold` is high whenever `dec_rs_a` or `dec_rs_b` names an empty register.
- R5: Up to NUM_ENTRIES lines can be outstanding at once. With all entries in use, a miss to an untracked line raises `miss_stall` in the same cycle and is not taken.
- R6: A fill selects its entry with `fill_id`. Word k of the line is `fill_data[k*DATA_W +: DATA_W]`. Starting in the cycle after the fill, the entry's pending words appear on the writeback port one per cycle, lowest word index first. Each register reads full from the cycle after its writeback.
- R7: When several entries are draining, the lowest-indexed entry owns the writeback port until it has finished.
- R8: An entry is released in the cycle after its final writeback and can then be allocated again.
- R9: A new miss whose destination register is already waiting in any slot replaces that older request. The older slot is dropped and never written back.
- R10: A merge to a word whose slot already holds a different register stalls and is not taken.
- R11: A fill aimed at an entry that is not waiting for data has no effect: no writeback follows, and registers stay as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_valid | input | 1 | A load miss is presented |
| miss_line | input | LINE_W | Line address of the miss |
| miss_word | input | WORD_W | Word within the line |
| miss_rd | input | REG_W | Destination register |
| miss_stall | output | 1 | Miss cannot be taken this cycle |
| mem_req_valid | output | 1 | Line fetch request pulse |
| mem_req_line | output | LINE_W | Line to fetch |
| mem_req_id | output | ENT_W | Entry that will receive the fill |
| fill_valid | input | 1 | Memory returns a line |
| fill_id | input | ENT_W | Entry the line belongs to |
| fill_data | input | WORDS_PER_LINE*DATA_W | Whole line, word 0 in the low bits |
| wb_valid | output | 1 | Register write this cycle |
| wb_rd | output | REG_W | Register being written |
| wb_data | output | DATA_W | Value written |
| dec_rs_a | input | REG_W | First decode source register |
| dec_rs_b | input | REG_W | Second decode source register |
| dec_hold | output | 1 | A decode source is still empty |

## Verification
`miss_stall` and `dec_hold` are combinational, so the bench checks them a few nanoseconds after it changes the inputs, before the next edge. The memory request and the empty mark on a register appear one edge after the miss is accepted, and the bench checks them just after that edge. The first writeback comes one edge after the fill, and each later word follows one cycle after the one before. A monitor checks every writeback at the falling edge against a queue of expected register and data pairs, filled in the order R6 and R7 predict, so any extra, missing or reordered writeback is reported. Register-full checks are placed one edge after the writeback cycle, and entry reuse is checked by the entry index of the next allocation.

// File: rtl/mshr_pkg.sv
package mshr_pkg;
    parameter int NUM_ENTRIES    = 4;
    parameter int WORDS_PER_LINE = 4;
    parameter int NUM_REGS       = 32;
    parameter int LINE_W         = 26;
    parameter int DATA_W         = 32;

    localparam int ENT_W   = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;
    localparam int WORD_W  = (WORDS_PER_LINE > 1) ? $clog2(WORDS_PER_LINE) : 1;
    localparam int REG_W   = $clog2(NUM_REGS);
    localparam int LINE_DW = WORDS_PER_LINE * DATA_W;

    // one word slot: is a register waiting, and which one
    typedef struct packed {
        logic             pend;
        logic [REG_W-1:0] rd;
    } slot_t;

    typedef enum logic [1:0] {
        ENT_FREE  = 2'd0,
        ENT_WAIT  = 2'd1,
        ENT_DRAIN = 2'd2
    } ent_state_e;
endpackage

// File: rtl/mshr_entry.sv
module mshr_entry
    import mshr_pkg::*;
(
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            alloc_en,
    input  logic [LINE_W-1:0]               alloc_line,
    input  logic                            set_en,
    input  logic [WORD_W-1:0]               set_word,
    input  logic [REG_W-1:0]                set_rd,
    input  logic                            kill_en,
    input  logic [REG_W-1:0]                kill_rd,
    input  logic                            fill_en,
    input  logic [LINE_DW-1:0]              fill_data,
    input  logic                            wb_grant,
    output ent_state_e                      state,
    output logic [LINE_W-1:0]               line,
    output slot_t [WORDS_PER_LINE-1:0]      slots,
    output logic                            has_pend,
    output logic [REG_W-1:0]                head_rd,
    output logic [DATA_W-1:0]               head_data
);
    ent_state_e                  state_q, state_n;
    logic [LINE_W-1:0]           line_q;
    slot_t [WORDS_PER_LINE-1:0]  slots_q, slots_n;
    logic [LINE_DW-1:0]          data_q;
    logic [WORD_W-1:0]           head_word;
    logic                        pend_after;

    // lowest pending word is the next one to write back
    always_comb begin
        head_word = '0;
        has_pend  = 1'b0;
        for (int w = WORDS_PER_LINE - 1; w >= 0; w--) begin
            if (slots_q[w].pend) begin
                head_word = WORD_W'(w);
                has_pend  = 1'b1;
            end
        end
    end

    assign head_rd   = slots_q[head_word].rd;
    assign head_data = data_q[head_word*DATA_W +: DATA_W];

    // slot update: alloc clears, kill drops stale register, grant retires head, set wins last
    always_comb begin
        slots_n    = slots_q;
        pend_after = 1'b0;
        for (int w = 0; w < WORDS_PER_LINE; w++) begin
            if (alloc_en)
                slots_n[w].pend = 1'b0;
            if (kill_en && slots_q[w].pend && (slots_q[w].rd == kill_rd))
                slots_n[w].pend = 1'b0;
            if (wb_grant && (head_word == WORD_W'(w)))
                slots_n[w].pend = 1'b0;
            if (set_en && (set_word == WORD_W'(w))) begin
                slots_n[w].pend = 1'b1;
                slots_n[w].rd   = set_rd;
            end
            pend_after = pend_after | slots_n[w].pend;
        end
    end

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ENT_FREE:  if (alloc_en)    state_n = ENT_WAIT;
            ENT_WAIT:  if (fill_en)     state_n = ENT_DRAIN;
            ENT_DRAIN: if (!pend_after) state_n = ENT_FREE;
            default:                    state_n = ENT_FREE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ENT_FREE;
            line_q  <= '0;
            slots_q <= '0;
            data_q  <= '0;
        end else begin
            state_q <= state_n;
            slots_q <= slots_n;
            if (alloc_en)
                line_q <= alloc_line;
            if (fill_en && (state_q == ENT_WAIT))
                data_q <= fill_data;
        end
    end

    assign state = state_q;
    assign line  = line_q;
    assign slots = slots_q;

    AST_DRAIN_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (state_q == ENT_DRAIN && !has_pend) |=> (state_q == ENT_FREE)); // R8

    AST_GRANT_HAS_WORD: assert property (@(posedge clk) disable iff (rst)
        wb_grant |-> (state_q == ENT_DRAIN && has_pend)); // R6

    AST_FILL_FREE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (fill_en && !alloc_en && state_q == ENT_FREE) |=> (state_q == ENT_FREE)); // R11
endmodule

// File: rtl/mshr_wb_arbiter.sv
module mshr_wb_arbiter
    import mshr_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NUM_ENTRIES-1:0] req,
    output logic [NUM_ENTRIES-1:0] grant,
    output logic [ENT_W-1:0]       grant_idx,
    output logic                   any
);
    // fixed priority: lowest index wins
    always_comb begin
        grant     = '0;
        grant_idx = '0;
        any       = 1'b0;
        for (int i = 0; i < NUM_ENTRIES; i++) begin
            if (req[i] && !any) begin
                grant[i]  = 1'b1;
                grant_idx = ENT_W'(i);
                any       = 1'b1;
            end
        end
    end

    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant)); // R7

    AST_GRANT_REQUESTED: assert property (@(posedge clk) disable iff (rst)
        (grant & ~req) == '0); // R7
endmodule

// File: rtl/mshr_scoreboard.sv
module mshr_scoreboard
    import mshr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             set_en,
    input  logic [REG_W-1:0] set_rd,
    input  logic             clr_en,
    input  logic [REG_W-1:0] clr_rd,
    input  logic [REG_W-1:0] rs_a,
    input  logic [REG_W-1:0] rs_b,
    output logic             hold
);
    logic [NUM_REGS-1:0] busy_q, busy_n;

    // a new miss marking empty outranks a writeback marking full
    always_comb begin
        busy_n = busy_q;
        if (clr_en) busy_n[clr_rd] = 1'b0;
        if (set_en) busy_n[set_rd] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) busy_q <= '0;
        else     busy_q <= busy_n;
    end

    assign hold = busy_q[rs_a] | busy_q[rs_b];

    AST_WB_TARGET_EMPTY: assert property (@(posedge clk) disable iff (rst)
        clr_en |-> busy_q[clr_rd]); // R6

    AST_MISS_MARKS_EMPTY: assert property (@(posedge clk) disable iff (rst)
        set_en |=> busy_q[$past(set_rd)]); // R4
endmodule

// File: rtl/miss_tracker.sv
module miss_tracker
    import mshr_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                miss_valid,
    input  logic [LINE_W-1:0]   miss_line,
    input  logic [WORD_W-1:0]   miss_word,
    input  logic [REG_W-1:0]    miss_rd,
    output logic                miss_stall,
    output logic                mem_req_valid,
    output logic [LINE_W-1:0]   mem_req_line,
    output logic [ENT_W-1:0]    mem_req_id,
    input  logic                fill_valid,
    input  logic [ENT_W-1:0]    fill_id,
    input  logic [LINE_DW-1:0]  fill_data,
    output logic                wb_valid,
    output logic [REG_W-1:0]    wb_rd,
    output logic [DATA_W-1:0]   wb_data,
    input  logic [REG_W-1:0]    dec_rs_a,
    input  logic [REG_W-1:0]    dec_rs_b,
    output logic                dec_hold
);
    ent_state_e                  ent_st    [NUM_ENTRIES];
    logic [LINE_W-1:0]           ent_line  [NUM_ENTRIES];
    slot_t [WORDS_PER_LINE-1:0]  ent_slots [NUM_ENTRIES];
    logic                        ent_pend  [NUM_ENTRIES];
    logic [REG_W-1:0]            ent_hrd   [NUM_ENTRIES];
    logic [DATA_W-1:0]           ent_hdata [NUM_ENTRIES];

    logic [NUM_ENTRIES-1:0] alloc_vec, set_vec, drain_req, grant;
    logic [ENT_W-1:0]       hit_idx, free_idx, grant_idx;
    logic                   hit, any_free, conflict, accept;
    slot_t                  hit_slot;

    // look for a waiting entry on the same line and the lowest free entry
    always_comb begin
        hit      = 1'b0;
        hit_idx  = '0;
        any_free = 1'b0;
        free_idx = '0;
        for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
            if (ent_st[i] == ENT_WAIT && ent_line[i] == miss_line) begin
                hit     = 1'b1;
                hit_idx = ENT_W'(i);
            end
            if (ent_st[i] == ENT_FREE) begin
                any_free = 1'b1;
                free_idx = ENT_W'(i);
            end
        end
    end

    assign hit_slot   = ent_slots[hit_idx][miss_word];
    assign conflict   = hit && hit_slot.pend && (hit_slot.rd != miss_rd);
    assign miss_stall = miss_valid && (conflict || (!hit && !any_free));
    assign accept     = miss_valid && !miss_stall;

    always_comb begin
        alloc_vec = '0;
        set_vec   = '0;
        for (int i = 0; i < NUM_ENTRIES; i++) begin
            alloc_vec[i] = accept && !hit && (free_idx == ENT_W'(i));
            set_vec[i]   = accept && (hit ? (hit_idx == ENT_W'(i)) : alloc_vec[i]);
        end
    end

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_ent
        mshr_entry u_entry (
            .clk        (clk),
            .rst        (rst),
            .alloc_en   (alloc_vec[g]),
            .alloc_line (miss_line),
            .set_en     (set_vec[g]),
            .set_word   (miss_word),
            .set_rd     (miss_rd),
            .kill_en    (accept),
            .kill_rd    (miss_rd),
            .fill_en    (fill_valid && (fill_id == ENT_W'(g))),
            .fill_data  (fill_data),
            .wb_grant   (grant[g]),
            .state      (ent_st[g]),
            .line       (ent_line[g]),
            .slots      (ent_slots[g]),
            .has_pend   (ent_pend[g]),
            .head_rd    (ent_hrd[g]),
            .head_data  (ent_hdata[g])
        );
        assign drain_req[g] = (ent_st[g] == ENT_DRAIN) && ent_pend[g];
    end

    mshr_wb_arbiter u_arb (
        .clk       (clk),
        .rst       (rst),
        .req       (drain_req),
        .grant     (grant),
        .grant_idx (grant_idx),
        .any       (wb_valid)
    );

    assign wb_rd   = ent_hrd[grant_idx];
    assign wb_data = ent_hdata[grant_idx];

    mshr_scoreboard u_sb (
        .clk    (clk),
        .rst    (rst),
        .set_en (accept),
        .set_rd (miss_rd),
        .clr_en (wb_valid),
        .clr_rd (wb_rd),
        .rs_a   (dec_rs_a),
        .rs_b   (dec_rs_b),
        .hold   (dec_hold)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_req_valid <= 1'b0;
            mem_req_line  <= '0;
            mem_req_id    <= '0;
        end else begin
            mem_req_valid <= accept && !hit;
            if (accept && !hit) begin
                mem_req_line <= miss_line;
                mem_req_id   <= free_idx;
            end
        end
    end

    AST_REQ_TO_WAITING: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid |-> (ent_st[mem_req_id] == ENT_WAIT)); // R2

    for (genvar a = 0; a < NUM_ENTRIES; a++) begin : g_uniq_a
        for (genvar b = a + 1; b < NUM_ENTRIES; b++) begin : g_uniq_b
            AST_LINE_UNIQUE: assert property (@(posedge clk) disable iff (rst)
                !(ent_st[a] == ENT_WAIT && ent_st[b] == ENT_WAIT
                  && ent_line[a] == ent_line[b])); // R3
        end
    end
endmodule

// File: tb/test_miss_tracker.sv
module test_miss_tracker;
    import mshr_pkg::*;

    logic                clk = 1'b0;
    logic                rst;
    logic                miss_valid;
    logic [LINE_W-1:0]   miss_line;
    logic [WORD_W-1:0]   miss_word;
    logic [REG_W-1:0]    miss_rd;
    logic                miss_stall;
    logic                mem_req_valid;
    logic [LINE_W-1:0]   mem_req_line;
    logic [ENT_W-1:0]    mem_req_id;
    logic                fill_valid;
    logic [ENT_W-1:0]    fill_id;
    logic [LINE_DW-1:0]  fill_data;
    logic                wb_valid;
    logic [REG_W-1:0]    wb_rd;
    logic [DATA_W-1:0]   wb_data;
    logic [REG_W-1:0]    dec_rs_a;
    logic [REG_W-1:0]    dec_rs_b;
    logic                dec_hold;

    miss_tracker i_miss_tracker (.*);

    always #10 clk = ~clk; // 50 MHz

    typedef struct {
        logic [REG_W-1:0]  rd;
        logic [DATA_W-1:0] data;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done   = 1'b0;

    task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [LINE_DW-1:0] make_line(logic [DATA_W-1:0] base);
        logic [LINE_DW-1:0] v;
        for (int k = 0; k < WORDS_PER_LINE; k++)
            v[k*DATA_W +: DATA_W] = base + DATA_W'(k);
        return v;
    endfunction

    function automatic logic [DATA_W-1:0] word_of(logic [DATA_W-1:0] base, int k);
        return base + DATA_W'(k);
    endfunction

    task automatic expect_wb(int rd, logic [DATA_W-1:0] data);
        exp_t e;
        e.rd   = REG_W'(rd);
        e.data = data;
        exp_q.push_back(e);
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic set_miss(int line, int word, int rd);
        miss_valid = 1'b1;
        miss_line  = LINE_W'(line);
        miss_word  = WORD_W'(word);
        miss_rd    = REG_W'(rd);
    endtask

    task automatic probe(int rs, string tag, logic exp);
        dec_rs_a = REG_W'(rs);
        dec_rs_b = REG_W'(0);
        #1;
        check(tag, $sformatf("dec_hold for r%0d", rs), 64'(dec_hold), 64'(exp));
    endtask

    // monitor: every writeback must match the head of the expected queue (R6, R7)
    always @(negedge clk) begin
        if (!rst && wb_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R6 R7 unexpected writeback actual=r%0d:%0h expected=none",
                         wb_rd, wb_data);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (wb_rd !== e.rd || wb_data !== e.data) begin
                    errors++;
                    $display("FAIL R6 R7 writeback actual=r%0d:%0h expected=r%0d:%0h",
                             wb_rd, wb_data, e.rd, e.data);
                end
            end
        end
    end

    initial begin
        #(20 * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; miss_valid = 1'b0; miss_line = '0; miss_word = '0; miss_rd = '0;
        fill_valid = 1'b0; fill_id = '0; fill_data = '0; dec_rs_a = '0; dec_rs_b = '0;
        repeat (3) step();
        rst = 1'b0;
        #1;
        // R1 reset state
        check("R1", "wb_valid", 64'(wb_valid), 64'd0);
        check("R1", "mem_req_valid", 64'(mem_req_valid), 64'd0);
        probe(5, "R1", 1'b0);

        // R2 first miss allocates entry 0
        set_miss('h100, 2, 5);
        #1 check("R2", "miss_stall", 64'(miss_stall), 64'd0);
        step(); miss_valid = 1'b0;
        check("R2", "mem_req_valid", 64'(mem_req_valid), 64'd1);
        check("R2", "mem_req_line", 64'(mem_req_line), 64'h100);
        check("R2", "mem_req_id", 64'(mem_req_id), 64'd0);
        probe(5, "R4", 1'b1);
        step();
        check("R2", "mem_req pulse ends", 64'(mem_req_valid), 64'd0);

        // R3 merge into the same line
        set_miss('h100, 0, 7);
        #1 check("R3", "miss_stall", 64'(miss_stall), 64'd0);
        step(); miss_valid = 1'b0;
        check("R3", "no mem request", 64'(mem_req_valid), 64'd0);
        dec_rs_b = REG_W'(7); dec_rs_a = REG_W'(1);
        #1 check("R4", "dec_hold via rs_b", 64'(dec_hold), 64'd1);

        // R9 r7 moves to a new line, entry 1
        set_miss('h200, 3, 7);
        step(); miss_valid = 1'b0;
        check("R9", "mem_req_id", 64'(mem_req_id), 64'd1);

        // R10 conflicting merge into an occupied word
        set_miss('h100, 2, 11);
        #1 check("R10", "miss_stall", 64'(miss_stall), 64'd1);
        step(); miss_valid = 1'b0;
        check("R10", "no mem request", 64'(mem_req_valid), 64'd0);
        probe(11, "R10", 1'b0);

        // R6 fill entry 0: only r5 (word 2) remains waiting there
        expect_wb(5, word_of(32'hA000_0000, 2));
        fill_valid = 1'b1; fill_id = '0; fill_data = make_line(32'hA000_0000);
        step(); fill_valid = 1'b0;
        #1 check("R6", "wb one cycle after fill", 64'(wb_valid), 64'd1);
        step();
        probe(5, "R6", 1'b0);
        probe(7, "R9", 1'b1);
        check("R9", "no writeback of dropped slot", 64'(wb_valid), 64'd0);
        step();

        expect_wb(7, word_of(32'hB000_0000, 3));
        fill_valid = 1'b1; fill_id = ENT_W'(1); fill_data = make_line(32'hB000_0000);
        step(); fill_valid = 1'b0;
        repeat (3) step();
        probe(7, "R6", 1'b0);

        // R5 fill every entry
        for (int i = 0; i < NUM_ENTRIES; i++) begin
            set_miss('h300 + i, 0, 12 + i);
            step();
            check("R5", "mem_req_id", 64'(mem_req_id), 64'(i));
        end
        set_miss('h303, 1, 23); step();
        set_miss('h303, 2, 24); step();
        set_miss('h302, 3, 25); step();
        set_miss('h400, 0, 16);
        #1 check("R5", "miss_stall when full", 64'(miss_stall), 64'd1);
        miss_valid = 1'b0;

        // R7 entry 2 overtakes entry 3 once both are draining
        expect_wb(15, word_of(32'hC300_0000, 0));
        expect_wb(14, word_of(32'hC200_0000, 0));
        expect_wb(25, word_of(32'hC200_0000, 3));
        expect_wb(23, word_of(32'hC300_0000, 1));
        expect_wb(24, word_of(32'hC300_0000, 2));
        fill_valid = 1'b1; fill_id = ENT_W'(3); fill_data = make_line(32'hC300_0000);
        step();
        fill_id = ENT_W'(2); fill_data = make_line(32'hC200_0000);
        step(); fill_valid = 1'b0;
        repeat (6) step();
        check("R7", "drain queue empty", 64'(exp_q.size()), 64'd0);

        // R8 freed entry 2 is reused
        set_miss('h400, 0, 16);
        #1 check("R8", "miss_stall", 64'(miss_stall), 64'd0);
        step(); miss_valid = 1'b0;
        check("R8", "reused entry id", 64'(mem_req_id), 64'd2);

        // R11 fill to a free entry does nothing
        fill_valid = 1'b1; fill_id = ENT_W'(3); fill_data = make_line(32'hEEEE_0000);
        step(); fill_valid = 1'b0;
        #1 check("R11", "no writeback", 64'(wb_valid), 64'd0);
        step();
        check("R11", "no writeback later", 64'(wb_valid), 64'd0);
        probe(16, "R11", 1'b1);

        // drain the rest
        expect_wb(16, word_of(32'hD000_0000, 0));
        expect_wb(12, word_of(32'hE000_0000, 0));
        expect_wb(13, word_of(32'hF000_0000, 0));
        fill_valid = 1'b1; fill_id = ENT_W'(2); fill_data = make_line(32'hD000_0000);
        step();
        fill_id = ENT_W'(0); fill_data = make_line(32'hE000_0000);
        step();
        fill_id = ENT_W'(1); fill_data = make_line(32'hF000_0000);
        step(); fill_valid = 1'b0;
        repeat (5) step();
        check("R6", "all writebacks seen", 64'(exp_q.size()), 64'd0);
        probe(12, "R6", 1'b0);
        probe(13, "R6", 1'b0);
        probe(16, "R6", 1'b0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule